// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns memory requests from a small 8-bit-data, 16-bit-address core into external bus cycles. A request may be an opcode fetch, a data read or a data write. Each accepted request runs through four bus states, T1 to T4. Each state lasts three input clocks, counted by a sub-state counter that runs from 0 to 2. The cycle therefore takes twelve clocks. Position n (0 to 11) is the clock that starts n clocks after the accepting edge, so the state is n/3 and the sub-state is n%3.

The upper address byte has a dedicated output. The lower address byte and the data share one 8-bit port. This port is split into an output, an input and an active-high output enable. An active-high ALE strobe lets an external latch capture the lower address byte during T1. Reads and fetches release the shared port after T1 and assert an active-low read strobe. Writes keep the port driven and replace the address with the write data. An active-low write strobe runs from the middle of T1 to the start of T3. At the last clock of T4 the block returns the captured byte with a one-clock completion pulse. A new request may be taken in that same clock.

Top module: `mux_bus_seq`

## Requirements
- R1: After a request is accepted on a rising edge, the bus cycle occupies exactly positions 0 to 11, that is twelve clocks made of four states of three clocks each.
- R2: `addr_hi` carries bits 15..8 of the accepted address for all of positions 0 to 11 and does not change during that time. It is 0 while idle.
- R3: `ale` is high at positions 0 and 1 only. At positions 0 to 2, `ad_oe` is high and `ad_out` carries bits 7..0 of the address.
- R4: For a fetch (`req_kind` 2'b00) or a read (2'b01), `ad_oe` is low from position 3 on, and `rd_n` is low at positions 3 to 8 only.
- R5: For read-type cycles, `ad_in` is sampled on the rising edge that ends position 8 (end of T3). That value appears on `rdata` at position 11 and is held until the next read-type capture. A write leaves `rdata` unchanged.
- R6: For a write (`req_kind[1]` = 1), `ad_oe` stays high through position 8 and is low at positions 9 to 11. `ad_out` carries the write data at positions 3 to 8.
- R7: For a write, `wr_n` is low at positions 1 to 5 only. `rd_n` stays high during a write, and `wr_n` stays high during read-type cycles.
- R8: While no cycle is in progress, `rd_n` and `wr_n` are high, and `ale`, `ad_oe`, `done` and `op_done` are low.
- R9: `req_ready` is high when idle and at position 11, and low at positions 0 to 10. A request presented while `req_ready` is low is ignored.
- R10: `done` is high for exactly one clock, at position 11. `op_done` is high with it only for an opcode fetch.
- R11: A request accepted at position 11 starts its position 0 on the very next clock, with no idle clock between the two cycles.
- R12: A synchronous reset, applied at any point, returns the block to the idle state of R8 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; three clocks make one bus state |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 opcode fetch, 01 read, 1x write |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted on this edge if valid |
| done | output | 1 | One-clock completion pulse at the end of T4 |
| op_done | output | 1 | Completion of an opcode fetch |
| rdata | output | 8 | Byte captured at the end of T3 |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared port, outgoing address or data |
| ad_in | input | 8 | Shared port, incoming data |
| ad_oe | output | 1 | Output enable for the shared port |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The completion of one cycle and the acceptance of the next can fall on the same clock. At position 11, `done` is high and a held `req_valid` is taken on the same edge. The bench provokes this by presenting a second request, with a different address and kind, at position 11 of a read. It then checks that `rdata` still shows the first cycle's byte during that clock. It also checks that the next clock is already position 0 of the new cycle, with the new upper address byte and ALE high. A separate scenario holds requests during a busy cycle to show that they do not shorten or redirect it.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int SUBS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic          op_done,
  output logic [DW-1:0] rdata,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] ad_out,
  input  logic [DW-1:0] ad_in,
  output logic          ad_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n
);
  localparam int SW = (SUBS > 2) ? $clog2(SUBS) : 1;
  localparam logic [SW-1:0] SLAST = SW'(SUBS - 1);
  localparam logic [SW-1:0] SMID  = SW'(SUBS / 2);

  logic          busy, is_wr, is_fetch;
  logic [1:0]    st;
  logic [SW-1:0] sub;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  wire last    = busy && st == 2'd3 && sub == SLAST;
  wire capture = busy && !is_wr && st == 2'd2 && sub == SLAST;

  assign req_ready = !busy || last;
  assign done      = last;
  assign op_done   = last && is_fetch;
  assign addr_hi   = busy ? addr_q[AW-1:DW] : '0;
  assign ale       = busy && st == 2'd0 && sub < SLAST;
  assign ad_oe     = busy && (st == 2'd0 || (is_wr && st != 2'd3));
  assign ad_out    = !busy ? '0 : (st == 2'd0) ? addr_q[DW-1:0] : (is_wr ? wdata_q : '0);
  assign rd_n      = !(busy && !is_wr && (st == 2'd1 || st == 2'd2));
  assign wr_n      = !(busy && is_wr && ((st == 2'd0 && sub >= SMID) || st == 2'd1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      st       <= '0;
      sub      <= '0;
      is_wr    <= 1'b0;
      is_fetch <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata    <= '0;
    end else begin
      if (capture) rdata <= ad_in;
      if (req_ready && req_valid) begin
        busy     <= 1'b1;
        st       <= '0;
        sub      <= '0;
        is_wr    <= req_kind[1];
        is_fetch <= req_kind == 2'b00;
        addr_q   <= req_addr;
        wdata_q  <= req_wdata;
      end else if (last) begin
        busy <= 1'b0;
        st   <= '0;
        sub  <= '0;
      end else if (busy) begin
        if (sub == SLAST) begin
          sub <= '0;
          st  <= st + 2'd1;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (rd_n && wr_n && !ad_oe && !ale && !done));
  a_r4_no_contention: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  a_r3_ale_drives: assert property (@(posedge clk) disable iff (rst)
    ale |-> ad_oe);
  a_r2_hi_stable: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(req_ready)) |-> $stable(addr_hi));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    (done && !req_valid) |=> !done);
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !req_ready) |=> busy);
endmodule

// File: tb/mux_bus_seq_tb.sv
module mux_bus_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic req_valid = 0;
  logic [1:0] req_kind = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0, ad_in = 0;
  logic req_ready, done, op_done, ad_oe, ale, rd_n, wr_n;
  logic [7:0] rdata, addr_hi, ad_out;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .op_done(op_done), .rdata(rdata), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n));

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(string req);
    chk(req, "rd_n", rd_n, 1);
    chk(req, "wr_n", wr_n, 1);
    chk(req, "ale", ale, 0);
    chk(req, "ad_oe", ad_oe, 0);
    chk(req, "done", done, 0);
    chk(req, "op_done", op_done, 0);
    chk(req, "addr_hi", addr_hi, 0);
    chk(req, "req_ready", req_ready, 1);
  endtask

  task automatic check_pos(int n, logic [1:0] k, logic [15:0] a, logic [7:0] wd);
    bit w = k[1];
    chk("R1/R9", $sformatf("req_ready@%0d", n), req_ready, n == 11);
    chk("R2", $sformatf("addr_hi@%0d", n), addr_hi, a[15:8]);
    chk("R3", $sformatf("ale@%0d", n), ale, n < 2);
    chk(w ? "R6" : "R4", $sformatf("ad_oe@%0d", n), ad_oe, w ? (n < 9) : (n < 3));
    if (n < 3) chk("R3", $sformatf("ad_out@%0d", n), ad_out, a[7:0]);
    else if (w && n < 9) chk("R6", $sformatf("ad_out@%0d", n), ad_out, wd);
    chk(w ? "R7" : "R4", $sformatf("rd_n@%0d", n), rd_n, !(!w && n >= 3 && n <= 8));
    chk("R7", $sformatf("wr_n@%0d", n), wr_n, !(w && n >= 1 && n <= 5));
    chk("R10", $sformatf("done@%0d", n), done, n == 11);
    chk("R10", $sformatf("op_done@%0d", n), op_done, n == 11 && k == 2'b00);
  endtask

  task automatic issue(logic [1:0] k, logic [15:0] a, logic [7:0] wd);
    req_valid = 1; req_kind = k; req_addr = a; req_wdata = wd;
  endtask

  // runs positions 0..11 of a cycle already accepted; poke drives busy-time requests
  task automatic run_body(logic [1:0] k, logic [15:0] a, logic [7:0] wd, logic [7:0] rd,
                          logic [7:0] prev_rdata, bit poke);
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      req_valid = 0;
      if (poke && n >= 1 && n <= 10) issue(2'b10, ~a, 8'h5A);
      ad_in = (n == 8) ? rd : ~rd;
      check_pos(n, k, a, wd);
      if (n == 11) chk("R5", "rdata@11", rdata, k[1] ? prev_rdata : rd);
      if (n == 11) req_valid = 0;
    end
  endtask

  task automatic t_cycle(logic [1:0] k, logic [15:0] a, logic [7:0] wd, logic [7:0] rd, bit poke);
    logic [7:0] prev;
    @(negedge clk);
    prev = rdata;
    issue(k, a, wd);
    run_body(k, a, wd, rd, prev, poke);
    @(negedge clk);
    check_idle(poke ? "R9" : "R8");
    chk("R5", "rdata idle", rdata, k[1] ? prev : rd);
  endtask

  task automatic t_chain;
    @(negedge clk);
    issue(2'b01, 16'h3C71, 0);
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      req_valid = 0;
      ad_in = (n == 8) ? 8'hE4 : 8'h1B;
      check_pos(n, 2'b01, 16'h3C71, 0);
      if (n == 11) begin
        chk("R11", "rdata with done", rdata, 8'hE4);
        issue(2'b00, 16'h9D02, 0);
      end
    end
    run_body(2'b00, 16'h9D02, 0, 8'h66, 8'hE4, 0);
    @(negedge clk);
    check_idle("R11");
  endtask

  task automatic t_reset;
    @(negedge clk);
    issue(2'b10, 16'h7755, 8'h99);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      req_valid = 0;
    end
    chk("R12", "wr_n before reset", wr_n, 0);
    rst = 1;
    @(negedge clk);
    check_idle("R12");
    rst = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R12");
    chk("R12", "rdata reset", rdata, 0);
    rst = 0;
    @(negedge clk);
    check_idle("R8");
    t_cycle(2'b00, 16'hA512, 0, 8'hC3, 0);
    t_cycle(2'b01, 16'h00FF, 0, 8'h3A, 0);
    t_cycle(2'b10, 16'hFF00, 8'h81, 8'h44, 0);
    t_cycle(2'b11, 16'h1234, 8'h7E, 8'h10, 0);
    t_cycle(2'b01, 16'h4D2B, 0, 8'hB6, 1);
    t_chain();
    t_reset();
    t_cycle(2'b01, 16'h8001, 0, 8'h29, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule